// File: doc/BRIEF.md
# Boundary Scan Pad Interception Chain

This block is a boundary scan register that sits between core logic and the IO pads. It takes a list of pads set by a parameter, and each pad has one of four kinds: input only, output only, tristate output, or bidirectional. Each wire that a pad kind actually has (input, output, output enable) is tapped. A tap holds two scan bits: one on the core side and one on the pad side. When production mode is active, core and pad connect straight through, pin by pin. When scan mode is active, both sides are intercepted. The chain samples what the core and the pad present. It also drives, from its own latched bits, whatever the core and the pad would normally receive.

An external test access port controller operates the chain through three strobes (capture, shift, update), a serial input and a serial output, all on the test clock. The controller's state machine, its instruction register and the physical pad cells are not part of this block. All logic is synchronous to the test clock and has no minimum rate. A peripheral clock that enters on a pad is handled like any other input wire.

Top module: `bscan_chain`

## Requirements
- R1: Pad kind codes (2 bits per pad, pad 0 in the lowest bits) are 0 = input only, 1 = output only, 2 = tristate output, 3 = bidirectional. A wire a kind lacks is not tapped and has a fixed value: `core_i` is 0 for kinds 1 and 2. `pad_o` is 0 for kind 0. `pad_oe` is 1 for kind 1 and 0 for kind 0.
- R2: With `scan_mode` low, every tapped wire passes straight through: `core_i` follows `pad_i`, `pad_o` follows `core_o`, and `pad_oe` follows `core_oe`, whatever the update latches hold.
- R3: With `scan_mode` high, every tapped wire's destination (`core_i` for an input wire, `pad_o`/`pad_oe` for output wires) takes that wire's update latch, not its source.
- R4: Chain index 0 sits next to `tdo`. Pads come in list order. Within a pad, the input wire comes first, then the output, then the output enable. Within a wire, the core-side bit comes before the pad-side bit. The length is 2 bits per tapped wire (14 for the default list).
- R5: On `capture_dr`, observing cells load what they watch: the pad-side bit of an input wire loads `pad_i`, and the core-side bit of an output wire loads `core_o`/`core_oe`. Driving cells load their own update latch.
- R6: On `shift_dr` (without `capture_dr`), each chain bit takes its neighbour from the `tdi` side, the last index takes `tdi`, and `tdo` shows index 0.
- R7: Update latches load the driving cells' shift bits only on `update_dr` and hold through capture and shift.
- R8: A low `rst_n` at a clock edge clears all shift bits and update latches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_mode | input | 1 | High: intercept core and pads; low: straight through |
| capture_dr | input | 1 | Load observed values into the shift bits |
| shift_dr | input | 1 | Shift the chain one bit toward `tdo` |
| update_dr | input | 1 | Copy driving shift bits into update latches |
| tdi | input | 1 | Serial data into the last chain index |
| tdo | output | 1 | Serial data from chain index 0 |
| pad_i | input | NUM_PADS | Value received at each pad |
| core_i | output | NUM_PADS | Input value presented to the core |
| core_o | input | NUM_PADS | Output value from the core |
| core_oe | input | NUM_PADS | Output enable from the core |
| pad_o | output | NUM_PADS | Output value sent to each pad |
| pad_oe | output | NUM_PADS | Output enable sent to each pad |

## Verification
The bench builds the block with its default parameters: four pads, one of each kind, in the order input, output, tristate, bidirectional. This gives a 14-bit chain. That list covers every combination of present and absent wires and every kind of cell, observing and driving, on both sides. Each chain offset can therefore be checked from a single capture pattern and a single drive pattern. The straight-through vectors run while the update latches hold non-zero values, which shows that production mode ignores them.

// File: rtl/bscan_pkg.sv
// Package: shared pad-kind type and constant functions for the scan chain.
// Assumes kind lists are packed 2 bits per pad with pad 0 in the low bits,
// zero-extended to MAX_PADS entries.
package bscan_pkg;

    localparam int MAX_PADS = 64;
    localparam int KINDS_W  = 2 * MAX_PADS;

    typedef enum logic [1:0] {
        KIND_IN    = 2'd0,
        KIND_OUT   = 2'd1,
        KIND_TRI   = 2'd2,
        KIND_BIDIR = 2'd3
    } pad_kind_e;

    function automatic pad_kind_e kind_at(input logic [KINDS_W-1:0] kinds, input int p);
        return pad_kind_e'(kinds[2*p +: 2]);
    endfunction

    function automatic bit has_in(input pad_kind_e k);
        return (k == KIND_IN) || (k == KIND_BIDIR);
    endfunction

    function automatic bit has_out(input pad_kind_e k);
        return (k != KIND_IN);
    endfunction

    function automatic bit has_oe(input pad_kind_e k);
        return (k == KIND_TRI) || (k == KIND_BIDIR);
    endfunction

    function automatic int wire_bits(input pad_kind_e k);
        return 2 * (int'(has_in(k)) + int'(has_out(k)) + int'(has_oe(k)));
    endfunction

    // First chain index used by pad p (equals total length when p = pad count).
    function automatic int pad_base(input logic [KINDS_W-1:0] kinds, input int p);
        int acc = 0;
        for (int q = 0; q < MAX_PADS; q++) begin
            if (q < p) acc += wire_bits(kind_at(kinds, q));
        end
        return acc;
    endfunction

    // sel 0: has input, 1: has output, 2: has enable, 3: output-only kind.
    function automatic logic [MAX_PADS-1:0] kind_mask(input logic [KINDS_W-1:0] kinds,
                                                      input int n, input int sel);
        logic [MAX_PADS-1:0] m = '0;
        for (int q = 0; q < MAX_PADS; q++) begin
            if (q < n) begin
                case (sel)
                    0:       m[q] = has_in(kind_at(kinds, q));
                    1:       m[q] = has_out(kind_at(kinds, q));
                    2:       m[q] = has_oe(kind_at(kinds, q));
                    default: m[q] = (kind_at(kinds, q) == KIND_OUT);
                endcase
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/bscan_cell.sv
// Module: one shift stage of the scan chain.
// Loads its capture value on capture, else takes the serial input on shift.
// Assumes capture and shift are not both asserted by the controller; capture wins.
module bscan_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic cap_val,
    input  logic si,
    output logic q
);

    // Shift flop: reset, capture, or shift.
    always_ff @(posedge clk) begin
        if (!rst_n)          q <= 1'b0;
        else if (capture_dr) q <= cap_val;
        else if (shift_dr)   q <= si;
    end

endmodule

// File: rtl/bscan_wire_tap.sv
// Module: interception of one pad wire.
// Holds a core-side and a pad-side shift cell; the pad-side cell is nearer tdi.
// DRIVE_CORE = 1 for an input wire (pad to core): the pad-side cell observes
// the pad and the core-side cell, through an update latch, drives the core.
// DRIVE_CORE = 0 for an output wire (core to pad): the roles swap.
// The destination mux selects the update latch in scan mode, else the source.
module bscan_wire_tap #(
    parameter bit DRIVE_CORE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scan_mode,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic update_dr,
    input  logic src,
    output logic dst,
    input  logic si,
    output logic so
);

    logic core_q, pad_q, upd_q;
    logic core_cap, pad_cap, upd_d;

    if (DRIVE_CORE) begin : g_drive_core
        assign core_cap = upd_q;
        assign pad_cap  = src;
        assign upd_d    = core_q;
    end else begin : g_drive_pad
        assign core_cap = src;
        assign pad_cap  = upd_q;
        assign upd_d    = pad_q;
    end

    bscan_cell u_pad_cell (
        .clk(clk), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .cap_val(pad_cap), .si(si), .q(pad_q)
    );

    bscan_cell u_core_cell (
        .clk(clk), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .cap_val(core_cap), .si(pad_q), .q(core_q)
    );

    // Update latch: changes only on update, so shifting leaves outputs still.
    always_ff @(posedge clk) begin
        if (!rst_n)         upd_q <= 1'b0;
        else if (update_dr) upd_q <= upd_d;
    end

    assign dst = scan_mode ? upd_q : src;
    assign so  = core_q;

endmodule

// File: rtl/bscan_chain.sv
// Module: boundary scan chain across a parameterised list of pads.
// Each pad kind taps only the wires it has; absent wires get fixed values.
// Chain index 0 feeds tdo; tdi enters at the last index.
// Assumes an external controller sequences capture/shift/update on clk.
module bscan_chain #(
    parameter int                    NUM_PADS  = 4,
    parameter logic [2*NUM_PADS-1:0] PAD_KINDS = 8'hE4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scan_mode,
    input  logic                capture_dr,
    input  logic                shift_dr,
    input  logic                update_dr,
    input  logic                tdi,
    output logic                tdo,
    input  logic [NUM_PADS-1:0] pad_i,
    output logic [NUM_PADS-1:0] core_i,
    input  logic [NUM_PADS-1:0] core_o,
    input  logic [NUM_PADS-1:0] core_oe,
    output logic [NUM_PADS-1:0] pad_o,
    output logic [NUM_PADS-1:0] pad_oe
);

    import bscan_pkg::*;

    localparam logic [KINDS_W-1:0] KINDS_EXT = KINDS_W'(PAD_KINDS);
    localparam int CHAIN_LEN = pad_base(KINDS_EXT, NUM_PADS);

    logic [CHAIN_LEN:0]  link;
    logic [NUM_PADS-1:0] unused_pad_i, unused_core_o, unused_core_oe;

    assign link[CHAIN_LEN] = tdi;
    assign tdo             = link[0];

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        localparam pad_kind_e KIND    = kind_at(KINDS_EXT, p);
        localparam int        BASE    = pad_base(KINDS_EXT, p);
        localparam int        OUT_OFF = BASE + (has_in(KIND) ? 2 : 0);
        localparam int        OE_OFF  = OUT_OFF + 2;

        // Input wire: pad to core.
        if (has_in(KIND)) begin : g_in
            bscan_wire_tap #(.DRIVE_CORE(1'b1)) u_tap (
                .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode),
                .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
                .src(pad_i[p]), .dst(core_i[p]),
                .si(link[BASE+2]), .so(link[BASE])
            );
            assign unused_pad_i[p] = 1'b0;
        end else begin : g_no_in
            assign core_i[p]       = 1'b0;
            assign unused_pad_i[p] = pad_i[p];
        end

        // Output wire: core to pad.
        if (has_out(KIND)) begin : g_out
            bscan_wire_tap #(.DRIVE_CORE(1'b0)) u_tap (
                .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode),
                .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
                .src(core_o[p]), .dst(pad_o[p]),
                .si(link[OUT_OFF+2]), .so(link[OUT_OFF])
            );
            assign unused_core_o[p] = 1'b0;
        end else begin : g_no_out
            assign pad_o[p]         = 1'b0;
            assign unused_core_o[p] = core_o[p];
        end

        // Output enable wire: core to pad; output-only pads drive permanently.
        if (has_oe(KIND)) begin : g_oe
            bscan_wire_tap #(.DRIVE_CORE(1'b0)) u_tap (
                .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode),
                .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
                .src(core_oe[p]), .dst(pad_oe[p]),
                .si(link[OE_OFF+2]), .so(link[OE_OFF])
            );
            assign unused_core_oe[p] = 1'b0;
        end else begin : g_no_oe
            assign pad_oe[p]         = (KIND == KIND_OUT);
            assign unused_core_oe[p] = core_oe[p];
        end
    end

endmodule

// File: rtl/bscan_chain_chk.sv
// Checker: port-level properties of bscan_chain, attached by bind below.
// Assumes rst_n is held low at time zero.
module bscan_chain_chk #(
    parameter int                    NUM_PADS  = 4,
    parameter logic [2*NUM_PADS-1:0] PAD_KINDS = 8'hE4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                scan_mode,
    input logic                update_dr,
    input logic                tdo,
    input logic [NUM_PADS-1:0] pad_i,
    input logic [NUM_PADS-1:0] core_i,
    input logic [NUM_PADS-1:0] core_o,
    input logic [NUM_PADS-1:0] core_oe,
    input logic [NUM_PADS-1:0] pad_o,
    input logic [NUM_PADS-1:0] pad_oe
);

    import bscan_pkg::*;

    localparam logic [KINDS_W-1:0]  KX     = KINDS_W'(PAD_KINDS);
    localparam logic [NUM_PADS-1:0] IN_M   = NUM_PADS'(kind_mask(KX, NUM_PADS, 0));
    localparam logic [NUM_PADS-1:0] OUT_M  = NUM_PADS'(kind_mask(KX, NUM_PADS, 1));
    localparam logic [NUM_PADS-1:0] OE_M   = NUM_PADS'(kind_mask(KX, NUM_PADS, 2));
    localparam logic [NUM_PADS-1:0] OHI_M  = NUM_PADS'(kind_mask(KX, NUM_PADS, 3));

    // R1: absent wires hold their fixed values.
    assert_absent_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_i & ~IN_M) == '0) && ((pad_o & ~OUT_M) == '0) && ((pad_oe & ~OE_M) == OHI_M));

    // R2: production mode connects core and pad directly.
    assert_bypass_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_mode |-> ((((core_i ^ pad_i) & IN_M) == '0) &&
                        (((pad_o ^ core_o) & OUT_M) == '0) &&
                        (((pad_oe ^ core_oe) & OE_M) == '0)));

    // R7: in scan mode, driven values move only after an update strobe.
    assert_hold_without_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_mode && !update_dr) |=>
            (!scan_mode || ($stable(pad_o) && $stable(pad_oe) && $stable(core_i))));

    // R8: the chain output is cleared by reset.
    assert_tdo_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (tdo == 1'b0));

endmodule

bind bscan_chain bscan_chain_chk #(.NUM_PADS(NUM_PADS), .PAD_KINDS(PAD_KINDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .update_dr(update_dr),
    .tdo(tdo), .pad_i(pad_i), .core_i(core_i), .core_o(core_o),
    .core_oe(core_oe), .pad_o(pad_o), .pad_oe(pad_oe)
);

// File: tb/bscan_chain_tb.sv
// Bench: default pad list (input, output, tristate, bidirectional), 14-bit chain.
module bscan_chain_tb;

    localparam int N   = 4;
    localparam int LEN = 14;

    logic clk = 1'b0;
    logic rst_n, scan_mode, capture_dr, shift_dr, update_dr, tdi, tdo;
    logic [N-1:0] pad_i, core_i, core_o, core_oe, pad_o, pad_oe;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    bscan_chain #(.NUM_PADS(N), .PAD_KINDS(8'hE4)) u_dut (
        .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .pad_i(pad_i), .core_i(core_i), .core_o(core_o), .core_oe(core_oe),
        .pad_o(pad_o), .pad_oe(pad_oe)
    );

    // Straight-through vectors: {pad_i, core_o, core_oe, exp core_i, exp pad_o, exp pad_oe}
    localparam logic [23:0] BYPASS_VEC [4] = '{24'hFFF9EE, 24'h000002, 24'h695086, 24'h96A96A};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Capture, shift LEN bits, update; mid returns pad_o after 7 shifts.
    task automatic scan_dr(input logic [LEN-1:0] din, output logic [LEN-1:0] dout,
                           output logic [N-1:0] mid);
        @(negedge clk) capture_dr = 1'b1;
        for (int k = 0; k < LEN; k++) begin
            @(negedge clk);
            capture_dr = 1'b0;
            shift_dr   = 1'b1;
            dout[k]    = tdo;
            tdi        = din[k];
            if (k == 7) mid = pad_o;
        end
        @(negedge clk) begin shift_dr = 1'b0; update_dr = 1'b1; end
        @(negedge clk) update_dr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [LEN-1:0] dout;
        logic [N-1:0]   mid;
        rst_n = 1'b0; scan_mode = 1'b1; capture_dr = 1'b0; shift_dr = 1'b0;
        update_dr = 1'b0; tdi = 1'b0;
        pad_i = 4'hF; core_o = 4'hF; core_oe = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state, R3 latches drive in scan mode, R1 fixed wires
        check("R8 tdo after reset", tdo, 0);
        check("R8 core_i from cleared latches", core_i, 4'h0);
        check("R3 pad_o from cleared latches", pad_o, 4'h0);
        check("R1 pad_oe fixed for output-only", pad_oe, 4'h2);

        // Scan 1: R5 observe, R4 order, R3/R7 drive after update
        pad_i = 4'h9; core_o = 4'hA; core_oe = 4'h4;
        scan_dr(14'h288F, dout, mid);
        check("R5 captured observed bits", dout, 14'h0646);
        check("R7 pad_o held while shifting", mid, 4'h0);
        check("R3 core_i intercepted", core_i, 4'h1);
        check("R3 pad_o driven", pad_o, 4'hA);
        check("R4 pad_oe driven", pad_oe, 4'hE);

        // R2 straight-through with non-zero latches
        @(negedge clk) scan_mode = 1'b0;
        foreach (BYPASS_VEC[i]) begin
            @(negedge clk);
            {pad_i, core_o, core_oe} = BYPASS_VEC[i][23:12];
            #2;
            check("R2 core_i bypass", core_i, BYPASS_VEC[i][11:8]);
            check("R2 pad_o bypass", pad_o, BYPASS_VEC[i][7:4]);
            check("R1 R2 pad_oe bypass", pad_oe, BYPASS_VEC[i][3:0]);
        end

        // Back to scan mode: latched values return
        @(negedge clk) begin scan_mode = 1'b1; pad_i = 4'hF; core_o = 4'h0; end
        #2;
        check("R3 pad_o latch retained", pad_o, 4'hA);
        check("R3 core_i ignores pad_i", core_i, 4'h1);

        // Scan 2: R5 readback of driving cells, R7 hold during shift
        pad_i = 4'h0; core_o = 4'h0; core_oe = 4'h8;
        scan_dr(14'h0000, dout, mid);
        check("R5 readback and observe", dout, 14'h3889);
        check("R7 pad_o held while shifting", mid, 4'hA);
        check("R7 pad_o after update", pad_o, 4'h0);
        check("R7 pad_oe after update", pad_oe, 4'h2);

        // R6 shift-only: a bit takes LEN shifts to reach tdo
        for (int k = 0; k < LEN; k++) begin
            @(negedge clk);
            shift_dr = 1'b1;
            tdi      = (k == 0);
            if (k == LEN - 1) check("R6 tdo before last shift", tdo, 0);
        end
        @(negedge clk) begin shift_dr = 1'b0; tdi = 1'b0; end
        check("R6 R4 bit reaches tdo after chain length", tdo, 1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule